// File: doc/BRIEF.md
# DDR SDRAM Burst Column Sequencer

This block produces the column address for each data beat of one SDRAM read or write burst. The controller supplies a start column, a burst-length code, an ordering select, an auto-precharge bit and a read/write select, and pulses a start strobe. The length, ordering and column would normally come from a mode register. The block then emits one column per clock, where each beat stands for one double-rate data pair, and flags both the valid beats and the final beat.

The block supports bursts of 2, 4 and 8 beats in sequential or interleaved order, and a 256-beat full-page burst in sequential order. A full-page request is illegal if it asks for interleaved order or gives an odd start column. The block answers such a request with a one-cycle error pulse and runs no beats. For reads, the first beat is held back by the fixed read latency. The auto-precharge bit travels with the burst and is never part of the column.

Top module: `ddr_burst_agen`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle. `beat_valid_o`, `last_o`, `err_o`, `ap_o` and `col_o` are all 0.
- R2: `blen_i` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives a full page of 256. Beats come on consecutive clocks, and `last_o` is high only on the final beat.
- R3: With `itlv_i`=0 and a length of 2, 4 or 8, beat k has the column whose upper bits match the start column. Its low log2(length) bits equal the start's low bits plus k, taken modulo the length.
- R4: With `itlv_i`=1 and a length of 2, 4 or 8, beat k has the start column with its low log2(length) bits XORed with k. The upper bits are unchanged.
- R5: A full-page sequential burst emits the start column plus k, taken modulo 256, for k from 0 to 255.
- R6: A full-page request with `itlv_i`=1 raises `err_o` for exactly the one cycle after the start edge and produces no beats.
- R7: A full-page request whose start column has bit 0 set raises `err_o` for exactly the one cycle after the start edge and produces no beats.
- R8: For a write (`is_read_i`=0), beat 0 is valid in the cycle after the edge that accepts the start. For a read (`is_read_i`=1), beat 0 comes RD_LAT (default 3) cycles after that.
- R9: `ap_o` shows the start's auto-precharge bit on every beat of the burst. It is 0 when no beat is valid.
- R10: A legal start accepted during a burst stops that burst at once. The new sequence then starts from the new column.
- R11: A start presented in a cycle where `err_o` is high is ignored, whether it is legal or not.
- R12: An illegal request leaves a burst already in progress running unchanged.
- R13: `col_o` is 0 whenever `beat_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| is_read_i | input | 1 | 1 = read (latency applied), 0 = write |
| start_col_i | input | COL_W | Starting column |
| ap_i | input | 1 | Auto-precharge bit carried with the burst |
| blen_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3=full page |
| itlv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column for the current beat |
| ap_o | output | 1 | Auto-precharge bit during beats |
| beat_valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | Illegal request reported |

## Verification
A wrong beat counter or wrong wrap mask shows up at `col_o` on the first beat that should wrap. That is at most seven clocks into a short burst, and at the 256-to-0 step of a full page. A bad end index shows as `last_o` on the wrong beat, or as an extra valid beat, on the very next clock. A wrong latency counter moves the first read beat by whole cycles. A stale error state shows as a second error pulse or as a swallowed start one clock after the request. Because every port is compared against the reference on every clock, each of these faults is seen within the burst in which it first acts.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;
  typedef enum logic [1:0] {
    BLEN_2    = 2'd0,
    BLEN_4    = 2'd1,
    BLEN_8    = 2'd2,
    BLEN_PAGE = 2'd3
  } blen_e;
endpackage

// File: rtl/ddr_burst_legal.sv
module ddr_burst_legal
  import ddr_burst_pkg::*;
(
  input  blen_e blen,
  input  logic  itlv,
  input  logic  col_lsb,
  output logic  bad
);
  // full page: sequential order and even start only
  always_comb begin
    bad = (blen == BLEN_PAGE) && (itlv || col_lsb);
  end
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  blen_e            blen,
  input  logic             itlv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    case (blen)
      BLEN_2:  wrap_mask = COL_W'(1);
      BLEN_4:  wrap_mask = COL_W'(3);
      BLEN_8:  wrap_mask = COL_W'(7);
      default: wrap_mask = '1;
    endcase
    sum = base + beat;
  end

  // per bit: bits inside the wrap window move, the rest keep the start value
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = wrap_mask[i] ? (itlv ? (base[i] ^ beat[i]) : sum[i]) : base[i];
  end
endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int RD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bad,
  input  logic             is_read,
  input  logic [COL_W-1:0] col,
  input  logic             ap,
  input  blen_e            blen,
  input  logic             itlv,
  output logic             valid,
  output logic             last,
  output logic             err,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output blen_e            blen_q_o,
  output logic             itlv_o,
  output logic             ap_o
);
  logic             active_q, active_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             err_q, err_d;
  logic [COL_W-1:0] base_q;
  blen_e            blen_q;
  logic             itlv_q, ap_q;
  logic [COL_W-1:0] last_idx;
  logic             accept, load, wait_done, at_end;

  assign accept = start && !err_q;
  assign load   = accept && !bad;
  assign err_d  = accept && bad;

  always_comb begin
    case (blen_q)
      BLEN_2:  last_idx = COL_W'(1);
      BLEN_4:  last_idx = COL_W'(3);
      BLEN_8:  last_idx = COL_W'(7);
      default: last_idx = '1;
    endcase
  end

  assign valid  = active_q && wait_done;
  assign at_end = (beat_q == last_idx);
  assign last   = valid && at_end;

  // next state
  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (load) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (valid) begin
      if (at_end) active_d = 1'b0;
      else        beat_d   = beat_q + COL_W'(1);
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
      err_q    <= err_d;
    end
  end

  // burst parameters, loaded under enable
  always_ff @(posedge clk) begin
    if (load) begin
      base_q <= col;
      blen_q <= blen;
      itlv_q <= itlv;
      ap_q   <= ap;
    end
  end

  if (RD_LAT > 0) begin : g_rdlat
    localparam int WAIT_W = $clog2(RD_LAT + 1);
    logic [WAIT_W-1:0] wait_q, wait_d;
    always_comb begin
      wait_d = wait_q;
      if (load)               wait_d = is_read ? WAIT_W'(RD_LAT) : '0;
      else if (wait_q != '0)  wait_d = wait_q - WAIT_W'(1);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else        wait_q <= wait_d;
    end
    assign wait_done = (wait_q == '0);
  end else begin : g_nolat
    logic unused_rd;
    assign unused_rd = is_read;
    assign wait_done = 1'b1;
  end

  assign err      = err_q;
  assign beat     = beat_q;
  assign base     = base_q;
  assign blen_q_o = blen_q;
  assign itlv_o   = itlv_q;
  assign ap_o     = ap_q;
endmodule

// File: rtl/ddr_burst_agen.sv
module ddr_burst_agen
  import ddr_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int RD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_read_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             ap_i,
  input  logic [1:0]       blen_i,
  input  logic             itlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             ap_o,
  output logic             beat_valid_o,
  output logic             last_o,
  output logic             err_o
);
  blen_e            blen_in, blen_q;
  logic             bad, valid, last, err, itlv_q, ap_q;
  logic [COL_W-1:0] beat, base, col;

  assign blen_in = blen_e'(blen_i);

  ddr_burst_legal u_legal (
    .blen    (blen_in),
    .itlv    (itlv_i),
    .col_lsb (start_col_i[0]),
    .bad     (bad)
  );

  ddr_burst_seq #(.COL_W(COL_W), .RD_LAT(RD_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .bad      (bad),
    .is_read  (is_read_i),
    .col      (start_col_i),
    .ap       (ap_i),
    .blen     (blen_in),
    .itlv     (itlv_i),
    .valid    (valid),
    .last     (last),
    .err      (err),
    .beat     (beat),
    .base     (base),
    .blen_q_o (blen_q),
    .itlv_o   (itlv_q),
    .ap_o     (ap_q)
  );

  ddr_burst_colgen #(.COL_W(COL_W)) u_col (
    .base (base),
    .beat (beat),
    .blen (blen_q),
    .itlv (itlv_q),
    .col  (col)
  );

  assign col_o        = valid ? col : '0;
  assign ap_o         = valid && ap_q;
  assign beat_valid_o = valid;
  assign last_o       = last;
  assign err_o        = err;
endmodule

// File: rtl/ddr_burst_agen_chk.sv
module ddr_burst_agen_chk #(
  parameter int COL_W  = 8,
  parameter int RD_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             is_read_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             ap_i,
  input logic [1:0]       blen_i,
  input logic             itlv_i,
  input logic [COL_W-1:0] col_o,
  input logic             ap_o,
  input logic             beat_valid_o,
  input logic             last_o,
  input logic             err_o
);
  logic req_bad, req_ok;
  assign req_bad = (blen_i == 2'd3) && (itlv_i || start_col_i[0]);
  assign req_ok  = start_i && !err_o && !req_bad;

  p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !err_o && req_bad |=> err_o);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  p_last_in_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);

  p_gap_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !last_o && !start_i |=> beat_valid_o);

  p_first_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok && !is_read_i |=> beat_valid_o && (col_o == $past(start_col_i)) && (ap_o == $past(ap_i)));

  p_rd_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok && is_read_i && (RD_LAT > 0) |=> !beat_valid_o);
endmodule

bind ddr_burst_agen ddr_burst_agen_chk #(.COL_W(COL_W), .RD_LAT(RD_LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .is_read_i    (is_read_i),
  .start_col_i  (start_col_i),
  .ap_i         (ap_i),
  .blen_i       (blen_i),
  .itlv_i       (itlv_i),
  .col_o        (col_o),
  .ap_o         (ap_o),
  .beat_valid_o (beat_valid_o),
  .last_o       (last_o),
  .err_o        (err_o)
);

// File: tb/ddr_burst_agen_test.sv
module ddr_burst_agen_test;
  localparam int RD_LAT = 3;

  typedef struct packed {
    logic       v;
    logic       l;
    logic       a;
    logic [7:0] c;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, is_read_i = 1'b0, ap_i = 1'b0, itlv_i = 1'b0;
  logic [7:0] start_col_i = 8'd0;
  logic [1:0] blen_i = 2'd0;
  logic [7:0] col_o;
  logic       ap_o, beat_valid_o, last_o, err_o;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  exp_t q[$];
  bit   m_err = 1'b0;
  bit   m_acc, m_bad;
  int   m_len;

  always #5 clk = ~clk;

  ddr_burst_agen uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_read_i(is_read_i),
    .start_col_i(start_col_i), .ap_i(ap_i), .blen_i(blen_i), .itlv_i(itlv_i),
    .col_o(col_o), .ap_o(ap_o), .beat_valid_o(beat_valid_o), .last_o(last_o),
    .err_o(err_o)
  );

  function automatic int len_of(input logic [1:0] code);
    case (code)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] col_of(input int b, input int k, input int len, input bit il);
    int lo, hi;
    if (len == 256) return 8'((b + k) % 256);
    lo = b % len;
    hi = b - lo;
    if (il) return 8'(hi + (lo ^ k));
    return 8'(hi + ((lo + k) % len));
  endfunction

  // reference model: a queue holds expected port values for coming cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_err = 1'b0;
    end else begin
      m_acc = start_i && !m_err;
      m_bad = (blen_i == 2'd3) && (itlv_i || start_col_i[0]);
      if (m_acc && !m_bad) begin
        q.delete();
        if (is_read_i) for (int i = 0; i < RD_LAT; i++) q.push_back('0);
        m_len = len_of(blen_i);
        for (int k = 0; k < m_len; k++)
          q.push_back('{v: 1'b1, l: (k == m_len - 1), a: ap_i,
                        c: col_of(int'(start_col_i), k, m_len, itlv_i)});
      end else if (q.size() > 0) begin
        void'(q.pop_front());
      end
      m_err = m_acc && m_bad;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (!finished) begin
      e = (q.size() > 0) ? q[0] : '0;
      vectors++;
      if (err_o !== m_err) begin
        miscompares++;
        $display("FAIL %s err_o act=%b exp=%b t=%0t", phase, err_o, m_err, $time);
      end
      if (beat_valid_o !== e.v) begin
        miscompares++;
        $display("FAIL %s beat_valid_o act=%b exp=%b t=%0t", phase, beat_valid_o, e.v, $time);
      end
      if (last_o !== e.l) begin
        miscompares++;
        $display("FAIL %s last_o act=%b exp=%b t=%0t", phase, last_o, e.l, $time);
      end
      if (ap_o !== e.a) begin
        miscompares++;
        $display("FAIL %s ap_o act=%b exp=%b t=%0t", phase, ap_o, e.a, $time);
      end
      if (col_o !== e.c) begin
        miscompares++;
        $display("FAIL %s R13 col_o act=%h exp=%h t=%0t", phase, col_o, e.c, $time);
      end
    end
  end

  task automatic req(input bit rd, input logic [7:0] col, input logic [1:0] len,
                     input bit il, input bit ap, input int gap);
    @(negedge clk);
    start_i = 1'b1; is_read_i = rd; start_col_i = col; blen_i = len; itlv_i = il; ap_i = ap;
    @(negedge clk);
    start_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R2"; req(0, 8'h35, 2'd0, 0, 0, 3);
    phase = "R2"; req(0, 8'h11, 2'd1, 0, 1, 6);
    phase = "R3"; req(0, 8'h36, 2'd1, 0, 0, 5);
    phase = "R3"; req(0, 8'h5D, 2'd2, 0, 1, 9);
    phase = "R4"; req(0, 8'h36, 2'd1, 1, 0, 5);
    phase = "R4"; req(0, 8'hA5, 2'd2, 1, 0, 9);
    phase = "R4"; req(0, 8'h73, 2'd0, 1, 1, 3);
    phase = "R5"; req(0, 8'hFE, 2'd3, 0, 1, 260);
    phase = "R8"; req(1, 8'h2B, 2'd2, 0, 0, 12);
    phase = "R8"; req(1, 8'h46, 2'd1, 1, 1, 9);
    phase = "R9"; req(0, 8'h80, 2'd2, 1, 1, 9);
    phase = "R6"; req(0, 8'h10, 2'd3, 1, 0, 4);
    phase = "R7"; req(0, 8'h21, 2'd3, 0, 0, 4);
    // R10: restart mid-burst
    phase = "R10"; req(0, 8'h40, 2'd2, 0, 0, 2);
    req(0, 8'h97, 2'd1, 0, 1, 6);
    phase = "R10"; req(1, 8'h08, 2'd2, 0, 0, 4);
    req(0, 8'hC2, 2'd0, 1, 0, 4);
    // R11: legal start in the error cycle is dropped
    phase = "R11";
    @(negedge clk);
    start_i = 1'b1; blen_i = 2'd3; itlv_i = 1'b1; start_col_i = 8'h00; is_read_i = 1'b0;
    @(negedge clk);
    blen_i = 2'd1; itlv_i = 1'b0; start_col_i = 8'h55; ap_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    // R12: illegal request during a running burst
    phase = "R12"; req(0, 8'h61, 2'd2, 0, 0, 1);
    req(0, 8'h33, 2'd3, 0, 0, 10);
    phase = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule